// File: doc/BRIEF.md
# Convolution Accelerator Control Register Block

This block is the CPU-facing control port of an image convolution accelerator. A processor reaches it over an AXI4-Lite slave port with a 32-bit data bus. Through it the processor loads the kernel weights, the image width and height, the source and destination base addresses and the burst length. It then issues a start command and watches a status word. The stored configuration drives the datapath and the DMA logic directly. Those units report back with one-cycle done and error strobes.

Commands are self-clearing bits in a control word. Start launches a run. A separate pair of soft resets serves different purposes: one returns the engine's run state to idle, and the other wipes the kernel weights. A start is refused while a run is in progress or while the geometry is incomplete, and a refusal is recorded as an error. Completion and errors latch in status flags that the software clears by writing ones. Each flag can also be routed to an interrupt line through its own enable bit.

Top module: `cnv_ctrl_regs`

## Requirements
- R1: A write takes effect and is answered only once both its address and its data have been accepted, in either order and possibly in different cycles. Each write produces exactly one B response. B and R responses hold until they are taken.
- R2: Word map, byte address = 4 × word index: 3 width, 4 height, 5 source base, 6 destination base, 7 burst length, and 8+k kernel weight k for k = 0..KCOEF_N-1. Width and height are DIM_W bits, the bases are PTR_W bits, the burst is BURST_W bits and the weights are COEF_W bits. Each reads back what was written, with the upper bits zero, and drives its output port. Weight k sits at bits [k*COEF_W +: COEF_W] of `coef_o`.
- R3: WSTRB bit b gates byte b of every writable register.
- R4: An address beyond the last weight, or one with nonzero bits [1:0], gets SLVERR (2'b10), changes nothing and reads as zero. Mapped accesses get OKAY (2'b00).
- R5: Writing 1 to control bit 0 (word 0) is refused when busy is set, or when width, height or burst is zero. A refused start produces no start pulse and sets the error flag.
- R6: An accepted start raises `start_o` for exactly one cycle and sets busy (status bit 0, word 1).
- R7: `eng_done_i` sets done (status bit 1) and `eng_err_i` sets error (status bit 2). Either one clears busy. Both flags stay set until cleared.
- R8: Writing 1 to status bit 1 or bit 2 clears that flag. Busy is not writable, and writing 0 has no effect.
- R9: `irq_o` is high when done is set with enable bit 0 of word 2, or error is set with enable bit 1 of word 2.
- R10: Control bit 1 pulses `eng_srst_o` for one cycle and clears busy, done and error. All configuration words are kept. A start written in the same word is dropped without error.
- R11: Control bit 2 pulses `kern_srst_o` for one cycle and zeroes all kernel weights. The other configuration words are kept.
- R12: After reset every register, flag, pulse and output is zero. Control reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_awaddr | input | ADDR_W | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | ADDR_W | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| eng_done_i | input | 1 | Run-complete strobe from the datapath |
| eng_err_i | input | 1 | Fault strobe from the datapath or DMA |
| start_o | output | 1 | One-cycle run launch |
| eng_srst_o | output | 1 | One-cycle engine soft reset |
| kern_srst_o | output | 1 | One-cycle kernel buffer soft reset |
| img_w_o | output | DIM_W | Image width |
| img_h_o | output | DIM_W | Image height |
| src_base_o | output | PTR_W | Source image base address |
| dst_base_o | output | PTR_W | Result base address |
| burst_len_o | output | BURST_W | DMA burst length |
| coef_o | output | KCOEF_N*COEF_W | Packed kernel weights |
| irq_o | output | 1 | Interrupt |

## Verification
Once the second of AW and W has been accepted, the write is applied at the next edge. The command pulses and B valid follow at that same edge, and read data appears one edge after the AR handshake. A strobe on `eng_done_i` or `eng_err_i` shows in status and on `irq_o` one edge later. The bench drives everything on the falling edge and counts pulse cycles on the falling edge as well. Each task reads its results back only after the B or R handshake that completes its access, so every sample falls after the edge at which the value is due. Pulse widths are verified by comparing the counted high cycles with the number of commands issued.

// File: rtl/cnv_ctrl_pkg.sv
package cnv_ctrl_pkg;
  localparam int unsigned REG_CTRL  = 0;
  localparam int unsigned REG_STAT  = 1;
  localparam int unsigned REG_IEN   = 2;
  localparam int unsigned REG_WID   = 3;
  localparam int unsigned REG_HGT   = 4;
  localparam int unsigned REG_SRC   = 5;
  localparam int unsigned REG_DST   = 6;
  localparam int unsigned REG_BURST = 7;
  localparam int unsigned REG_COEF0 = 8;

  localparam int CMD_START = 0;
  localparam int CMD_ESRST = 1;
  localparam int CMD_KSRST = 2;

  localparam int ST_BUSY = 0;
  localparam int ST_DONE = 1;
  localparam int ST_ERR  = 2;

  typedef enum logic [1:0] {
    RESP_OKAY   = 2'b00,
    RESP_SLVERR = 2'b10
  } axi_resp_e;
endpackage

// File: rtl/cnv_axil_port.sv
module cnv_axil_port
  import cnv_ctrl_pkg::*;
#(
  parameter int ADDR_W = 8,
  localparam int IDX_W = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] s_awaddr,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [31:0]       s_wdata,
  input  logic [3:0]        s_wstrb,
  input  logic              s_wvalid,
  output logic              s_wready,
  output logic [1:0]        s_bresp,
  output logic              s_bvalid,
  input  logic              s_bready,
  input  logic [ADDR_W-1:0] s_araddr,
  input  logic              s_arvalid,
  output logic              s_arready,
  output logic [31:0]       s_rdata,
  output logic [1:0]        s_rresp,
  output logic              s_rvalid,
  input  logic              s_rready,
  output logic              wr_en_o,
  output logic [IDX_W-1:0]  wr_idx_o,
  output logic [31:0]       wr_data_o,
  output logic [3:0]        wr_strb_o,
  input  logic              wr_hit_i,
  output logic [IDX_W-1:0]  rd_idx_o,
  input  logic [31:0]       rd_data_i,
  input  logic              rd_hit_i
);
  logic             aw_full_q, aw_full_d, aw_algn_q, aw_algn_d;
  logic [IDX_W-1:0] aw_idx_q, aw_idx_d;
  logic             w_full_q, w_full_d;
  logic [31:0]      w_data_q, w_data_d;
  logic [3:0]       w_strb_q, w_strb_d;
  logic             bvalid_q, bvalid_d, rvalid_q, rvalid_d;
  axi_resp_e        bresp_q, bresp_d, rresp_q, rresp_d;
  logic [31:0]      rdata_q, rdata_d;
  logic             aw_acc, w_acc, ar_acc, wr_go, wr_ok, rd_ok;

  always_comb begin
    aw_acc = s_awvalid & ~aw_full_q;
    w_acc  = s_wvalid & ~w_full_q;
    ar_acc = s_arvalid & ~rvalid_q;
    wr_go  = aw_full_q & w_full_q & ~bvalid_q;
    wr_ok  = wr_hit_i & aw_algn_q;
    rd_ok  = rd_hit_i & (s_araddr[1:0] == 2'b00);

    aw_full_d = wr_go ? 1'b0 : (aw_full_q | aw_acc);
    aw_idx_d  = aw_acc ? s_awaddr[ADDR_W-1:2] : aw_idx_q;
    aw_algn_d = aw_acc ? (s_awaddr[1:0] == 2'b00) : aw_algn_q;
    w_full_d  = wr_go ? 1'b0 : (w_full_q | w_acc);
    w_data_d  = w_acc ? s_wdata : w_data_q;
    w_strb_d  = w_acc ? s_wstrb : w_strb_q;

    bvalid_d = wr_go | (bvalid_q & ~s_bready);
    bresp_d  = wr_go ? (wr_ok ? RESP_OKAY : RESP_SLVERR) : bresp_q;

    rvalid_d = ar_acc | (rvalid_q & ~s_rready);
    rdata_d  = ar_acc ? (rd_ok ? rd_data_i : 32'h0) : rdata_q;
    rresp_d  = ar_acc ? (rd_ok ? RESP_OKAY : RESP_SLVERR) : rresp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aw_full_q <= 1'b0;
      aw_idx_q  <= '0;
      aw_algn_q <= 1'b0;
      w_full_q  <= 1'b0;
      w_data_q  <= '0;
      w_strb_q  <= '0;
      bvalid_q  <= 1'b0;
      bresp_q   <= RESP_OKAY;
      rvalid_q  <= 1'b0;
      rdata_q   <= '0;
      rresp_q   <= RESP_OKAY;
    end else begin
      aw_full_q <= aw_full_d;
      if (aw_acc) begin
        aw_idx_q  <= aw_idx_d;
        aw_algn_q <= aw_algn_d;
      end
      w_full_q <= w_full_d;
      if (w_acc) begin
        w_data_q <= w_data_d;
        w_strb_q <= w_strb_d;
      end
      bvalid_q <= bvalid_d;
      bresp_q  <= bresp_d;
      rvalid_q <= rvalid_d;
      if (ar_acc) begin
        rdata_q <= rdata_d;
        rresp_q <= rresp_d;
      end
    end
  end

  assign s_awready = ~aw_full_q;
  assign s_wready  = ~w_full_q;
  assign s_bvalid  = bvalid_q;
  assign s_bresp   = bresp_q;
  assign s_arready = ~rvalid_q;
  assign s_rvalid  = rvalid_q;
  assign s_rdata   = rdata_q;
  assign s_rresp   = rresp_q;
  assign wr_en_o   = wr_go & wr_ok;
  assign wr_idx_o  = aw_idx_q;
  assign wr_data_o = w_data_q;
  assign wr_strb_o = w_strb_q;
  assign rd_idx_o  = s_araddr[ADDR_W-1:2];

  AST_B_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(s_bvalid) |-> $past(aw_full_q && w_full_q)) else $error("AST_B_NEEDS_BOTH"); // R1
  AST_B_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    s_bvalid && !s_bready |=> s_bvalid && $stable(s_bresp)) else $error("AST_B_HOLD"); // R1
  AST_R_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    s_rvalid && !s_rready |=> s_rvalid && $stable(s_rdata)) else $error("AST_R_HOLD"); // R1
  AST_ERR_DATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    s_rvalid && s_rresp == 2'b10 |-> s_rdata == 32'h0) else $error("AST_ERR_DATA_ZERO"); // R4
endmodule

// File: rtl/cnv_ctrl_core.sv
module cnv_ctrl_core
  import cnv_ctrl_pkg::*;
#(
  parameter int IDX_W   = 6,
  parameter int KCOEF_N = 9,
  parameter int COEF_W  = 16,
  parameter int DIM_W   = 16,
  parameter int PTR_W   = 32,
  parameter int BURST_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en_i,
  input  logic [IDX_W-1:0]          wr_idx_i,
  input  logic [31:0]               wr_data_i,
  input  logic [3:0]                wr_strb_i,
  output logic                      wr_hit_o,
  input  logic [IDX_W-1:0]          rd_idx_i,
  output logic [31:0]               rd_data_o,
  output logic                      rd_hit_o,
  input  logic                      eng_done_i,
  input  logic                      eng_err_i,
  output logic                      start_o,
  output logic                      eng_srst_o,
  output logic                      kern_srst_o,
  output logic [DIM_W-1:0]          img_w_o,
  output logic [DIM_W-1:0]          img_h_o,
  output logic [PTR_W-1:0]          src_base_o,
  output logic [PTR_W-1:0]          dst_base_o,
  output logic [BURST_W-1:0]        burst_len_o,
  output logic [KCOEF_N*COEF_W-1:0] coef_o,
  output logic                      irq_o
);
  localparam int unsigned NREG = REG_COEF0 + KCOEF_N;

  logic [31:0]        wmask, cmd, m_wid, m_hgt, m_src, m_dst, m_bst, m_ien;
  logic [DIM_W-1:0]   wid_q, hgt_q;
  logic [PTR_W-1:0]   src_q, dst_q;
  logic [BURST_W-1:0] bst_q;
  logic [1:0]         ien_q;
  logic [COEF_W-1:0]  coef_q [KCOEF_N];
  logic busy_q, busy_d, done_q, done_d, err_q, err_d;
  logic start_q, esrst_q, ksrst_q;
  logic wr_ctrl, wr_stat, cfg_ok, start_req, start_acc, start_rej;
  logic esrst_req, ksrst_req, clr_done, clr_err;

  function automatic logic sel(input logic en, input logic [IDX_W-1:0] idx, input int unsigned r);
    return en && (idx == IDX_W'(r));
  endfunction

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw, input logic [31:0] m);
    return (old & ~m) | (nw & m);
  endfunction

  always_comb begin
    for (int b = 0; b < 4; b++) wmask[8*b +: 8] = {8{wr_strb_i[b]}};
    cmd   = wr_data_i & wmask;
    m_wid = merge(32'(wid_q), wr_data_i, wmask);
    m_hgt = merge(32'(hgt_q), wr_data_i, wmask);
    m_src = merge(32'(src_q), wr_data_i, wmask);
    m_dst = merge(32'(dst_q), wr_data_i, wmask);
    m_bst = merge(32'(bst_q), wr_data_i, wmask);
    m_ien = merge(32'(ien_q), wr_data_i, wmask);
  end

  assign wr_hit_o  = 32'(wr_idx_i) < NREG;
  assign wr_ctrl   = sel(wr_en_i, wr_idx_i, REG_CTRL);
  assign wr_stat   = sel(wr_en_i, wr_idx_i, REG_STAT);
  assign cfg_ok    = (wid_q != '0) && (hgt_q != '0) && (bst_q != '0);
  assign esrst_req = wr_ctrl & cmd[CMD_ESRST];
  assign ksrst_req = wr_ctrl & cmd[CMD_KSRST];
  assign start_req = wr_ctrl & cmd[CMD_START] & ~esrst_req;
  assign start_acc = start_req & ~busy_q & cfg_ok;
  assign start_rej = start_req & ~start_acc;
  assign clr_done  = wr_stat & cmd[ST_DONE];
  assign clr_err   = wr_stat & cmd[ST_ERR];

  always_comb begin
    if (esrst_req)                    busy_d = 1'b0;
    else if (start_acc)               busy_d = 1'b1;
    else if (eng_done_i || eng_err_i) busy_d = 1'b0;
    else                              busy_d = busy_q;
    if (esrst_req)       done_d = 1'b0;
    else if (eng_done_i) done_d = 1'b1;
    else if (clr_done)   done_d = 1'b0;
    else                 done_d = done_q;
    if (esrst_req)                   err_d = 1'b0;
    else if (eng_err_i || start_rej) err_d = 1'b1;
    else if (clr_err)                err_d = 1'b0;
    else                             err_d = err_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      start_q <= 1'b0;
      esrst_q <= 1'b0;
      ksrst_q <= 1'b0;
      wid_q   <= '0;
      hgt_q   <= '0;
      src_q   <= '0;
      dst_q   <= '0;
      bst_q   <= '0;
      ien_q   <= '0;
    end else begin
      busy_q  <= busy_d;
      done_q  <= done_d;
      err_q   <= err_d;
      start_q <= start_acc;
      esrst_q <= esrst_req;
      ksrst_q <= ksrst_req;
      if (sel(wr_en_i, wr_idx_i, REG_WID))   wid_q <= m_wid[DIM_W-1:0];
      if (sel(wr_en_i, wr_idx_i, REG_HGT))   hgt_q <= m_hgt[DIM_W-1:0];
      if (sel(wr_en_i, wr_idx_i, REG_SRC))   src_q <= m_src[PTR_W-1:0];
      if (sel(wr_en_i, wr_idx_i, REG_DST))   dst_q <= m_dst[PTR_W-1:0];
      if (sel(wr_en_i, wr_idx_i, REG_BURST)) bst_q <= m_bst[BURST_W-1:0];
      if (sel(wr_en_i, wr_idx_i, REG_IEN))   ien_q <= m_ien[1:0];
    end
  end

  for (genvar k = 0; k < KCOEF_N; k++) begin : g_coef
    logic              we;
    logic [31:0]       mk;
    logic [COEF_W-1:0] d;
    always_comb begin
      mk = merge(32'(coef_q[k]), wr_data_i, wmask);
      we = ksrst_req | sel(wr_en_i, wr_idx_i, REG_COEF0 + k);
      d  = ksrst_req ? '0 : mk[COEF_W-1:0];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  coef_q[k] <= '0;
      else if (we) coef_q[k] <= d;
    end
    assign coef_o[k*COEF_W +: COEF_W] = coef_q[k];
  end

  always_comb begin
    rd_hit_o  = 32'(rd_idx_i) < NREG;
    rd_data_o = '0;
    case (32'(rd_idx_i))
      REG_STAT:  rd_data_o = {29'h0, err_q, done_q, busy_q};
      REG_IEN:   rd_data_o = 32'(ien_q);
      REG_WID:   rd_data_o = 32'(wid_q);
      REG_HGT:   rd_data_o = 32'(hgt_q);
      REG_SRC:   rd_data_o = 32'(src_q);
      REG_DST:   rd_data_o = 32'(dst_q);
      REG_BURST: rd_data_o = 32'(bst_q);
      default: begin
        for (int k = 0; k < KCOEF_N; k++)
          if (32'(rd_idx_i) == REG_COEF0 + k) rd_data_o = 32'(coef_q[k]);
      end
    endcase
  end

  assign start_o     = start_q;
  assign eng_srst_o  = esrst_q;
  assign kern_srst_o = ksrst_q;
  assign img_w_o     = wid_q;
  assign img_h_o     = hgt_q;
  assign src_base_o  = src_q;
  assign dst_base_o  = dst_q;
  assign burst_len_o = bst_q;
  assign irq_o       = (done_q & ien_q[0]) | (err_q & ien_q[1]);

  AST_START_IDLE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> !$past(busy_q)) else $error("AST_START_IDLE_ONLY"); // R5
  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> !start_o) else $error("AST_START_PULSE"); // R6
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> busy_q) else $error("AST_START_BUSY"); // R6
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_q && !clr_err && !esrst_req |=> err_q) else $error("AST_ERR_STICKY"); // R7
  AST_CFG_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    eng_srst_o |-> $stable(wid_q) && $stable(src_q) && $stable(bst_q)) else $error("AST_CFG_KEPT"); // R10
  AST_KERN_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    kern_srst_o |-> coef_q[0] == '0) else $error("AST_KERN_CLEARED"); // R11
endmodule

// File: rtl/cnv_ctrl_regs.sv
module cnv_ctrl_regs #(
  parameter int ADDR_W  = 8,
  parameter int KCOEF_N = 9,
  parameter int COEF_W  = 16,
  parameter int DIM_W   = 16,
  parameter int PTR_W   = 32,
  parameter int BURST_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         s_awaddr,
  input  logic                      s_awvalid,
  output logic                      s_awready,
  input  logic [31:0]               s_wdata,
  input  logic [3:0]                s_wstrb,
  input  logic                      s_wvalid,
  output logic                      s_wready,
  output logic [1:0]                s_bresp,
  output logic                      s_bvalid,
  input  logic                      s_bready,
  input  logic [ADDR_W-1:0]         s_araddr,
  input  logic                      s_arvalid,
  output logic                      s_arready,
  output logic [31:0]               s_rdata,
  output logic [1:0]                s_rresp,
  output logic                      s_rvalid,
  input  logic                      s_rready,
  input  logic                      eng_done_i,
  input  logic                      eng_err_i,
  output logic                      start_o,
  output logic                      eng_srst_o,
  output logic                      kern_srst_o,
  output logic [DIM_W-1:0]          img_w_o,
  output logic [DIM_W-1:0]          img_h_o,
  output logic [PTR_W-1:0]          src_base_o,
  output logic [PTR_W-1:0]          dst_base_o,
  output logic [BURST_W-1:0]        burst_len_o,
  output logic [KCOEF_N*COEF_W-1:0] coef_o,
  output logic                      irq_o
);
  localparam int IDX_W = ADDR_W - 2;

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic             wr_en, wr_hit, rd_hit;
  logic [IDX_W-1:0] wr_idx, rd_idx;
  logic [31:0]      wr_data, rd_data;
  logic [3:0]       wr_strb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  cnv_axil_port #(.ADDR_W(ADDR_W)) port_i (
    .clk(clk), .rst_n(rst_int_n),
    .s_awaddr(s_awaddr), .s_awvalid(s_awvalid), .s_awready(s_awready),
    .s_wdata(s_wdata), .s_wstrb(s_wstrb), .s_wvalid(s_wvalid), .s_wready(s_wready),
    .s_bresp(s_bresp), .s_bvalid(s_bvalid), .s_bready(s_bready),
    .s_araddr(s_araddr), .s_arvalid(s_arvalid), .s_arready(s_arready),
    .s_rdata(s_rdata), .s_rresp(s_rresp), .s_rvalid(s_rvalid), .s_rready(s_rready),
    .wr_en_o(wr_en), .wr_idx_o(wr_idx), .wr_data_o(wr_data), .wr_strb_o(wr_strb),
    .wr_hit_i(wr_hit), .rd_idx_o(rd_idx), .rd_data_i(rd_data), .rd_hit_i(rd_hit)
  );

  cnv_ctrl_core #(
    .IDX_W(IDX_W), .KCOEF_N(KCOEF_N), .COEF_W(COEF_W),
    .DIM_W(DIM_W), .PTR_W(PTR_W), .BURST_W(BURST_W)
  ) core_i (
    .clk(clk), .rst_n(rst_int_n),
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(wr_data), .wr_strb_i(wr_strb),
    .wr_hit_o(wr_hit), .rd_idx_i(rd_idx), .rd_data_o(rd_data), .rd_hit_o(rd_hit),
    .eng_done_i(eng_done_i), .eng_err_i(eng_err_i),
    .start_o(start_o), .eng_srst_o(eng_srst_o), .kern_srst_o(kern_srst_o),
    .img_w_o(img_w_o), .img_h_o(img_h_o), .src_base_o(src_base_o), .dst_base_o(dst_base_o),
    .burst_len_o(burst_len_o), .coef_o(coef_o), .irq_o(irq_o)
  );
endmodule

// File: tb/cnv_ctrl_regs_tb_top.sv
module cnv_ctrl_regs_tb_top;
  localparam int KN = 9;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0]  awaddr = '0, araddr = '0;
  logic        awvalid = 1'b0, wvalid = 1'b0, bready = 1'b0, arvalid = 1'b0, rready = 1'b0;
  logic [31:0] wdata = '0;
  logic [3:0]  wstrb = '0;
  logic        awready, wready, bvalid, arready, rvalid;
  logic [1:0]  bresp, rresp;
  logic [31:0] rdata;
  logic        eng_done = 1'b0, eng_err = 1'b0;
  logic        start_o, eng_srst_o, kern_srst_o, irq_o;
  logic [15:0] img_w, img_h;
  logic [31:0] src_b, dst_b;
  logic [7:0]  burst;
  logic [KN*CW-1:0] coefs;

  int n_chk = 0, n_fail = 0, early_b = 0;
  int start_cnt = 0, esrst_cnt = 0, ksrst_cnt = 0, cyc = 0;
  logic [31:0] exp_src;

  always #4 clk = ~clk;

  cnv_ctrl_regs dut_i (
    .clk(clk), .rst_n(rst_n),
    .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(awready),
    .s_wdata(wdata), .s_wstrb(wstrb), .s_wvalid(wvalid), .s_wready(wready),
    .s_bresp(bresp), .s_bvalid(bvalid), .s_bready(bready),
    .s_araddr(araddr), .s_arvalid(arvalid), .s_arready(arready),
    .s_rdata(rdata), .s_rresp(rresp), .s_rvalid(rvalid), .s_rready(rready),
    .eng_done_i(eng_done), .eng_err_i(eng_err),
    .start_o(start_o), .eng_srst_o(eng_srst_o), .kern_srst_o(kern_srst_o),
    .img_w_o(img_w), .img_h_o(img_h), .src_base_o(src_b), .dst_base_o(dst_b),
    .burst_len_o(burst), .coef_o(coefs), .irq_o(irq_o)
  );

  always @(negedge clk) begin
    if (start_o)     start_cnt++;
    if (eng_srst_o)  esrst_cnt++;
    if (kern_srst_o) ksrst_cnt++;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      n_fail++;
      $display("FAIL watchdog expired act=%0d exp<100000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic axi_wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] s,
                        input int adly, output logic [1:0] r);
    bit aw_done, w_done, ahs, whs;
    int n;
    aw_done = 0; w_done = 0; n = 0;
    @(negedge clk);
    awaddr = a; wdata = d; wstrb = s; wvalid = 1'b1; awvalid = (adly == 0);
    while (!(aw_done && w_done)) begin
      ahs = awvalid && awready;
      whs = wvalid && wready;
      if (bvalid) early_b++;
      @(negedge clk);
      if (ahs) begin awvalid = 1'b0; aw_done = 1; end
      if (whs) begin wvalid = 1'b0; w_done = 1; end
      n++;
      if (n >= adly && !aw_done) awvalid = 1'b1;
    end
    bready = 1'b1;
    while (!bvalid) @(negedge clk);
    r = bresp;
    @(negedge clk);
    bready = 1'b0;
  endtask

  task automatic axi_rd(input logic [7:0] a, output logic [31:0] d, output logic [1:0] r);
    @(negedge clk);
    araddr = a; arvalid = 1'b1;
    while (!arready) @(negedge clk);
    @(negedge clk);
    arvalid = 1'b0; rready = 1'b1;
    while (!rvalid) @(negedge clk);
    d = rdata; r = rresp;
    @(negedge clk);
    rready = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    logic [1:0] r;
    axi_wr(a, d, 4'hF, 0, r);
    chk("R4 mapped write resp", 32'(r), 32'h0);
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    logic [1:0] r;
    axi_rd(a, d, r);
    chk(tag, d, exp);
  endtask

  task automatic pulse_eng(input logic dn, input logic er);
    @(negedge clk);
    eng_done = dn; eng_err = er;
    @(negedge clk);
    eng_done = 1'b0; eng_err = 1'b0;
  endtask

  function automatic logic [15:0] cval(input int k);
    return 16'h8000 | 16'(k * 16'h0111);
  endfunction

  task automatic t_reset();
    rd_chk("R12 status after reset", 8'h04, 32'h0);
    rd_chk("R12 width after reset", 8'h0C, 32'h0);
    rd_chk("R12 control reads zero", 8'h00, 32'h0);
    chk("R12 outputs after reset", {irq_o, start_o, img_w, burst}, 32'h0);
    chk("R12 coef port after reset", 32'(coefs == '0), 32'h1);
  endtask

  task automatic t_start_unconfigured();
    wr(8'h00, 32'h1);
    chk("R5 no pulse without geometry", start_cnt, 0);
    rd_chk("R5 refused start flags error", 8'h04, 32'h4);
    wr(8'h04, 32'h4);
    rd_chk("R8 error cleared by W1C", 8'h04, 32'h0);
  endtask

  task automatic t_config();
    wr(8'h0C, 32'hABCD_1234);
    rd_chk("R2 width truncated to field", 8'h0C, 32'h0000_1234);
    wr(8'h0C, 32'h40);
    wr(8'h10, 32'h30);
    wr(8'h14, 32'h1000_0000);
    wr(8'h18, 32'h2000_0400);
    wr(8'h1C, 32'h10);
    for (int k = 0; k < KN; k++) wr(8'(8'h20 + 4*k), 32'(cval(k)));
    rd_chk("R2 height readback", 8'h10, 32'h30);
    rd_chk("R2 dst readback", 8'h18, 32'h2000_0400);
    rd_chk("R2 burst readback", 8'h1C, 32'h10);
    for (int k = 0; k < KN; k++) begin
      rd_chk("R2 coef readback", 8'(8'h20 + 4*k), 32'(cval(k)));
      chk("R2 coef port slice", 32'(coefs[k*CW +: CW]), 32'(cval(k)));
    end
    chk("R2 geometry ports", {img_w, img_h}, {16'h40, 16'h30});
    chk("R2 base ports", src_b ^ dst_b, 32'h3000_0400);
    chk("R2 burst port", 32'(burst), 32'h10);
    exp_src = 32'h1000_0000;
  endtask

  task automatic t_strobes();
    logic [1:0] r;
    axi_wr(8'h14, 32'hDEAD_BEEF, 4'b0001, 0, r);
    exp_src = 32'h1000_00EF;
    rd_chk("R3 byte 0 only", 8'h14, exp_src);
    axi_wr(8'h14, 32'hCAFE_0000, 4'b1000, 0, r);
    exp_src = 32'hCA00_00EF;
    rd_chk("R3 byte 3 only", 8'h14, exp_src);
    chk("R3 src port", src_b, exp_src);
  endtask

  task automatic t_unmapped();
    logic [1:0] r;
    logic [31:0] d;
    axi_wr(8'hFC, 32'hFFFF_FFFF, 4'hF, 0, r);
    chk("R4 write beyond map SLVERR", 32'(r), 32'h2);
    axi_rd(8'h44, d, r);
    chk("R4 read past last coef SLVERR", 32'(r), 32'h2);
    chk("R4 error read data zero", d, 32'h0);
    axi_wr(8'h0E, 32'h0000_0099, 4'hF, 0, r);
    chk("R4 misaligned write SLVERR", 32'(r), 32'h2);
    rd_chk("R4 misaligned write had no effect", 8'h0C, 32'h40);
    axi_rd(8'h0D, d, r);
    chk("R4 misaligned read SLVERR", 32'(r), 32'h2);
  endtask

  task automatic t_split_write();
    logic [1:0] r;
    early_b = 0;
    axi_wr(8'h10, 32'h22, 4'hF, 3, r);
    chk("R1 no response before address", early_b, 0);
    chk("R1 late address resp", 32'(r), 32'h0);
    rd_chk("R1 late address write applied", 8'h10, 32'h22);
  endtask

  task automatic t_start_run();
    wr(8'h00, 32'h1);
    chk("R6 one start pulse cycle", start_cnt, 1);
    rd_chk("R6 busy after start", 8'h04, 32'h1);
    wr(8'h00, 32'h1);
    chk("R5 no pulse while busy", start_cnt, 1);
    rd_chk("R5 busy start flags error", 8'h04, 32'h5);
    wr(8'h04, 32'h5);
    rd_chk("R8 busy not writable, error cleared", 8'h04, 32'h1);
  endtask

  task automatic t_done_irq();
    wr(8'h08, 32'h1);
    pulse_eng(1'b1, 1'b0);
    rd_chk("R7 done set busy cleared", 8'h04, 32'h2);
    chk("R9 irq on enabled done", 32'(irq_o), 32'h1);
    wr(8'h04, 32'h0);
    rd_chk("R8 writing zero keeps done", 8'h04, 32'h2);
    wr(8'h04, 32'h2);
    rd_chk("R8 done cleared", 8'h04, 32'h0);
    chk("R9 irq drops with done", 32'(irq_o), 32'h0);
  endtask

  task automatic t_err_mask();
    wr(8'h00, 32'h1);
    chk("R6 second start accepted", start_cnt, 2);
    pulse_eng(1'b0, 1'b1);
    rd_chk("R7 error set busy cleared", 8'h04, 32'h4);
    chk("R9 masked error no irq", 32'(irq_o), 32'h0);
    wr(8'h08, 32'h3);
    chk("R9 enabled error irq", 32'(irq_o), 32'h1);
    wr(8'h04, 32'h4);
    chk("R9 irq drops with error", 32'(irq_o), 32'h0);
  endtask

  task automatic t_engine_reset();
    wr(8'h00, 32'h1);
    pulse_eng(1'b1, 1'b0);
    wr(8'h00, 32'h1);
    rd_chk("R10 setup busy and done", 8'h04, 32'h3);
    wr(8'h00, 32'h2);
    chk("R10 one engine reset pulse", esrst_cnt, 1);
    rd_chk("R10 flags cleared", 8'h04, 32'h0);
    rd_chk("R10 width kept", 8'h0C, 32'h40);
    rd_chk("R10 src kept", 8'h14, exp_src);
    wr(8'h00, 32'h3);
    chk("R10 start dropped with reset", start_cnt, 4);
    rd_chk("R10 no error for dropped start", 8'h04, 32'h0);
  endtask

  task automatic t_kernel_reset();
    wr(8'h00, 32'h4);
    chk("R11 one kernel reset pulse", ksrst_cnt, 1);
    chk("R11 coef port cleared", 32'(coefs == '0), 32'h1);
    rd_chk("R11 last coef cleared", 8'h40, 32'h0);
    rd_chk("R11 burst kept", 8'h1C, 32'h10);
    rd_chk("R11 height kept", 8'h10, 32'h22);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_start_unconfigured();
    t_config();
    t_strobes();
    t_unmapped();
    t_split_write();
    t_start_run();
    t_done_irq();
    t_err_mask();
    t_engine_reset();
    t_kernel_reset();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule